// File: doc/BRIEF.md
# Counter Channel Sticky Status Flags

This block holds the latched status flags of a single up/down counter channel. The counter runs either as a linear counter, which saturates and reports a level condition while it sits beyond its range, or as a ring counter, which reports a one-cycle pulse each time it wraps. A mode input picks which of the two event sources sets the overflow and underflow flags. A third flag records rising edges of the index input. The index input is first brought into the clock domain, then optionally inverted, then gated by an inhibit control.

Each flag latches on its event and stays set. It is cleared only when its own clear command goes from 0 to 1. A command held at 1 has no further effect. When an event and a clear edge land in the same clock, the event wins, so no event is lost. The flags are packed into a 16-bit status word that a host reads.

Top module: `cnt_status_flags`

## Requirements
- R1: After reset is asserted (rst_n low) and then released, the status word reads 0x0000.
- R2: With ring_mode=0, if ovf_cond is 1 at a clock edge, status bit 0 (overflow) is 1 after that edge. The bit stays 1 after ovf_cond returns to 0, until it is cleared.
- R3: With ring_mode=1, a 1 on ovf_roll at a clock edge sets status bit 0 after that edge. ovf_cond is ignored in ring mode, and ovf_roll is ignored in linear mode.
- R4: Status bit 1 (underflow) follows the same rules using udf_cond (linear) and udf_roll (ring), and stays set until it is cleared.
- R5: A 0-to-1 change of clr_ovf_cmd, clr_udf_cmd or clr_idx_cmd between two clock edges clears bit 0, 1 or 2 respectively at the second edge. Holding the command at 1 does not clear a flag that is set again later.
- R6: If a set event and a clear edge for the same flag happen at the same clock edge, the flag is 1 after that edge.
- R7: Status bit 2 (index) latches on a rising edge of the conditioned index. The conditioned index is the two-flop synchronized z_raw XOR z_invert, ANDed with NOT z_inhibit. A z_raw rise first seen at edge k sets bit 2 at edge k+2.
- R8: While z_inhibit is 1, the conditioned index is held at 0, so no index edge is seen. Releasing inhibit while the synchronized, inverted index is 1 gives an edge, and bit 2 is set at the next clock edge.
- R9: Bit 3 and bits 15 down to 4 of the status word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ring_mode | input | 1 | 0 = linear counter, 1 = ring counter |
| ovf_cond | input | 1 | Linear overflow condition level |
| ovf_roll | input | 1 | Ring rollover pulse |
| udf_cond | input | 1 | Linear underflow condition level |
| udf_roll | input | 1 | Ring roll-under pulse |
| z_raw | input | 1 | Asynchronous index input |
| z_invert | input | 1 | Invert the synchronized index |
| z_inhibit | input | 1 | Force the conditioned index low |
| clr_ovf_cmd | input | 1 | Overflow clear command, acts on its rising edge |
| clr_udf_cmd | input | 1 | Underflow clear command, acts on its rising edge |
| clr_idx_cmd | input | 1 | Index clear command, acts on its rising edge |
| status_word | output | 16 | Packed flags: bit 0 overflow, bit 1 underflow, bit 2 index, all other bits 0 |

## Verification
The bench builds the block with its defaults: a 16-bit status word and a two-stage index synchronizer. With two stages, the index latency is a fixed three edges, so the bench can check that the flag is still clear at the second edge and set at the third. The 16-bit width lets the reserved-bit check cover every unused bit of a full host word.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_UDF  = 1;
  localparam int FLAG_IDX  = 2;
  localparam int NUM_FLAGS = 3;

  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_RING   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/csf_z_cond.sv
module csf_z_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic z_raw,
  input  logic z_invert,
  input  logic z_inhibit,
  output logic z_rise
);
  localparam int EXT_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [EXT_W-1:0]       sync_ext;
  logic                   z_sync;
  logic                   z_gated;
  logic                   gz_q, gz_d;

  always_comb begin
    sync_ext = {sync_q, z_raw};
    sync_d   = sync_ext[SYNC_STAGES-1:0];
  end

  assign z_sync  = sync_q[SYNC_STAGES-1];
  assign z_gated = (z_sync ^ z_invert) & ~z_inhibit;

  always_comb begin
    gz_d = z_gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      gz_q   <= 1'b0;
    end else begin
      sync_q <= sync_d;
      gz_q   <= gz_d;
    end
  end

  assign z_rise = z_gated & ~gz_q;
endmodule

// File: rtl/csf_cmd_edge.sv
module csf_cmd_edge #(
  parameter int NUM_CMD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMD-1:0] cmd,
  output logic [NUM_CMD-1:0] cmd_rise
);
  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    logic hist_q, hist_d;

    always_comb begin
      hist_d = cmd[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= hist_d;
    end

    assign cmd_rise[g] = cmd[g] & ~hist_q;
  end
endmodule

// File: rtl/csf_sticky_flag.sv
module csf_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_evt | clr_evt;
    flag_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/cnt_status_flags.sv
module cnt_status_flags #(
  parameter int STATUS_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ring_mode,
  input  logic                ovf_cond,
  input  logic                ovf_roll,
  input  logic                udf_cond,
  input  logic                udf_roll,
  input  logic                z_raw,
  input  logic                z_invert,
  input  logic                z_inhibit,
  input  logic                clr_ovf_cmd,
  input  logic                clr_udf_cmd,
  input  logic                clr_idx_cmd,
  output logic [STATUS_W-1:0] status_word
);
  import csf_pkg::*;

  localparam int NF = NUM_FLAGS;

  cnt_mode_e       mode;
  logic            z_rise;
  logic [NF-1:0]   set_vec;
  logic [NF-1:0]   clr_vec;
  logic [NF-1:0]   cmd_vec;
  logic [NF-1:0]   flag_vec;

  assign mode = cnt_mode_e'(ring_mode);

  always_comb begin
    set_vec = '0;
    if (mode == MODE_RING) begin
      set_vec[FLAG_OVF] = ovf_roll;
      set_vec[FLAG_UDF] = udf_roll;
    end else begin
      set_vec[FLAG_OVF] = ovf_cond;
      set_vec[FLAG_UDF] = udf_cond;
    end
    set_vec[FLAG_IDX] = z_rise;
  end

  always_comb begin
    cmd_vec           = '0;
    cmd_vec[FLAG_OVF] = clr_ovf_cmd;
    cmd_vec[FLAG_UDF] = clr_udf_cmd;
    cmd_vec[FLAG_IDX] = clr_idx_cmd;
  end

  csf_z_cond #(.SYNC_STAGES(SYNC_STAGES)) u_zcond (
    .clk       (clk),
    .rst_n     (rst_n),
    .z_raw     (z_raw),
    .z_invert  (z_invert),
    .z_inhibit (z_inhibit),
    .z_rise    (z_rise)
  );

  csf_cmd_edge #(.NUM_CMD(NF)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_vec),
    .cmd_rise (clr_vec)
  );

  for (genvar f = 0; f < NF; f++) begin : g_flag
    csf_sticky_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec[f]),
      .clr_evt (clr_vec[f]),
      .flag    (flag_vec[f])
    );
  end

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NF; i++) status_word[i] = flag_vec[i];
  end
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int STATUS_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ring_mode,
  input logic                ovf_cond,
  input logic                ovf_roll,
  input logic                udf_cond,
  input logic                udf_roll,
  input logic                clr_ovf_cmd,
  input logic                clr_udf_cmd,
  input logic                clr_idx_cmd,
  input logic                z_rise,
  input logic [STATUS_W-1:0] status_word
);
  logic co_q, cu_q, ci_q;
  logic co_rise, cu_rise, ci_rise;
  logic ovf_set, udf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_q <= 1'b0; cu_q <= 1'b0; ci_q <= 1'b0;
    end else begin
      co_q <= clr_ovf_cmd; cu_q <= clr_udf_cmd; ci_q <= clr_idx_cmd;
    end
  end

  assign co_rise = clr_ovf_cmd & ~co_q;
  assign cu_rise = clr_udf_cmd & ~cu_q;
  assign ci_rise = clr_idx_cmd & ~ci_q;
  assign ovf_set = ring_mode ? ovf_roll : ovf_cond;
  assign udf_set = ring_mode ? udf_roll : udf_cond;

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[STATUS_W-1:3] == '0);

  // R2, R6: a linear overflow condition sets the flag even with a clear edge
  p_ovf_lin_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_mode && ovf_cond) |=> status_word[0]);

  p_ovf_ring_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_mode && ovf_roll) |=> status_word[0]);

  p_udf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    udf_set |=> status_word[1]);

  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[0] && !co_rise) |=> status_word[0]);

  p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[1] && !cu_rise) |=> status_word[1]);

  p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (co_rise && !ovf_set) |=> !status_word[0]);

  p_idx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_rise && !z_rise) |=> !status_word[2]);

  p_idx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    z_rise |=> status_word[2]);
endmodule

bind cnt_status_flags csf_checker #(.STATUS_W(STATUS_W)) u_chk (.*);

// File: tb/tb_cnt_status_flags.sv
module tb_cnt_status_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ring_mode, ovf_cond, ovf_roll, udf_cond, udf_roll;
  logic        z_raw, z_invert, z_inhibit;
  logic        clr_ovf_cmd, clr_udf_cmd, clr_idx_cmd;
  logic [15:0] status_word;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  cnt_status_flags dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input int bitn, input logic exp);
    n_tests++;
    if (status_word[bitn] !== exp) begin
      n_fail++;
      $display("FAIL %s: bit %0d actual %b expected %b", req, bitn, status_word[bitn], exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [15:0] mask, input logic [15:0] exp);
    n_tests++;
    if ((status_word & mask) !== exp) begin
      n_fail++;
      $display("FAIL %s: word actual %h expected %h", req, status_word & mask, exp);
    end
  endtask

  task automatic clr_pulse(input int which);
    case (which)
      0: clr_ovf_cmd = 1'b1;
      1: clr_udf_cmd = 1'b1;
      default: clr_idx_cmd = 1'b1;
    endcase
    step();
    clr_ovf_cmd = 1'b0; clr_udf_cmd = 1'b0; clr_idx_cmd = 1'b0;
    step();
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    ring_mode = 0; ovf_cond = 0; ovf_roll = 0; udf_cond = 0; udf_roll = 0;
    z_raw = 0; z_invert = 0; z_inhibit = 0;
    clr_ovf_cmd = 0; clr_udf_cmd = 0; clr_idx_cmd = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk_word("R1 reset", 16'hFFFF, 16'h0000);
  endtask

  task automatic t_linear;
    ring_mode = 0;
    ovf_roll = 1; step(); ovf_roll = 0;
    chk("R3 roll ignored in linear", 0, 1'b0);
    ovf_cond = 1; step();
    chk("R2 linear set", 0, 1'b1);
    ovf_cond = 0; step(4);
    chk("R2 sticky", 0, 1'b1);
    clr_ovf_cmd = 1; step();
    chk("R5 clear edge", 0, 1'b0);
    ovf_cond = 1; step(); ovf_cond = 0; step(2);
    chk("R5 held level no re-clear", 0, 1'b1);
    clr_ovf_cmd = 0; step();
    clr_ovf_cmd = 1; step();
    chk("R5 second edge clears", 0, 1'b0);
    clr_ovf_cmd = 0; step();
  endtask

  task automatic t_ring;
    ring_mode = 1;
    ovf_cond = 1; udf_cond = 1; step(3); ovf_cond = 0; udf_cond = 0;
    chk_word("R3 cond ignored in ring", 16'h0003, 16'h0000);
    ovf_roll = 1; step(); ovf_roll = 0;
    chk("R3 rollover set", 0, 1'b1);
    udf_roll = 1; step(); udf_roll = 0; step(3);
    chk("R4 roll-under sticky", 1, 1'b1);
    clr_pulse(1);
    chk("R5 udf clear", 1, 1'b0);
    chk("R5 ovf untouched by udf clear", 0, 1'b1);
    clr_pulse(0);
    ring_mode = 0;
    udf_cond = 1; step(); udf_cond = 0; step(2);
    chk("R4 linear underflow", 1, 1'b1);
    clr_pulse(1);
  endtask

  task automatic t_set_wins;
    ring_mode = 0;
    chk("R6 precondition", 0, 1'b0);
    clr_ovf_cmd = 1; ovf_cond = 1; step();
    ovf_cond = 0;
    chk("R6 set beats clear", 0, 1'b1);
    clr_ovf_cmd = 0; step();
    clr_ovf_cmd = 1; ring_mode = 1; ovf_roll = 1; step();
    ovf_roll = 0; clr_ovf_cmd = 0; ring_mode = 0;
    chk("R6 set beats clear when set", 0, 1'b1);
    step();
    clr_pulse(0);
  endtask

  task automatic t_z_plain;
    z_invert = 0; z_inhibit = 0;
    z_raw = 1; step();
    chk("R7 latency edge k", 2, 1'b0);
    step();
    chk("R7 latency edge k+1", 2, 1'b0);
    step();
    chk("R7 set at edge k+2", 2, 1'b1);
    z_raw = 0; step(4);
    chk("R7 sticky after fall", 2, 1'b1);
    clr_pulse(2);
    chk("R5 idx clear", 2, 1'b0);
  endtask

  task automatic t_z_invert;
    z_raw = 1; step(4);
    z_invert = 1; step(2);
    clr_pulse(2);
    chk("R7 invert setup", 2, 1'b0);
    z_raw = 0; step(2);
    chk("R7 inverted before k+2", 2, 1'b0);
    step();
    chk("R7 inverted fall sets flag", 2, 1'b1);
    clr_pulse(2);
  endtask

  task automatic t_z_inhibit;
    z_inhibit = 1; z_invert = 0; z_raw = 0; step(4);
    clr_pulse(2);
    z_raw = 1; step(6);
    chk("R8 inhibit blocks edge", 2, 1'b0);
    z_inhibit = 0; step();
    chk("R8 release gives edge", 2, 1'b1);
    chk_word("R9 reserved bits", 16'hFFF8, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_ring();
    t_set_wins();
    t_z_plain();
    t_z_invert();
    t_z_inhibit();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule